// File: doc/BRIEF.md
# Multi-Step LFSR Random Word Generator

This block produces a new pseudo-random word of `OUT_W` bits on each enabled clock cycle. Its source is a Fibonacci linear-feedback shift register of `REG_LEN` bits. A plain single-step register shifts by one position per cycle, so successive words taken from it overlap in all bits but one. This block avoids that by chaining `OUT_W` copies of the shift-and-feedback step in combinational logic. The register then moves `OUT_W` single steps per cycle, and the published word is made entirely of bits that were not in the previous word.

The register length may be larger than the word width. This stretches the repeat period to `2^REG_LEN - 1` single steps when the tap mask is maximal. A seed can be loaded at any time. The all-zero state would lock the register, so an all-zero seed is replaced with the built-in seed. An optional output stage swaps each even/odd bit pair, which is useful when the word feeds a dither path.

Top module: `lfsr_multistep`

## Requirements
- R1: While `rst_i` is high at a clock edge, the register takes `SEED_INIT` and `valid_o` goes low; after that edge `rnd_o` shows the low `OUT_W` bits of `SEED_INIT` (mapped per R10).
- R2: A single step computes f = XOR of the register bits whose `TAPS` bit is 1 (bit `REG_LEN-1` is always a tap), then the register becomes {reg[REG_LEN-2:0], f}; bit 0 receives f.
- R3: With `en_i` high and `load_i` low, each clock edge advances the register by exactly `OUT_W` single steps, and `rnd_o` is reg[OUT_W-1:0], so no bit of a word is carried over from the previous word.
- R4: With `en_i` and `load_i` both low, the register and `rnd_o` keep their values.
- R5: With `load_i` high, `en_i` low and `seed_i` non-zero, the register takes `seed_i` at the edge.
- R6: With `load_i` high, `en_i` low and `seed_i` all zero, the register takes `SEED_INIT` instead.
- R7: With `load_i` and `en_i` both high, the seed chosen by R5/R6 is advanced by `OUT_W` single steps at that same edge.
- R8: `valid_o` is low after reset and stays low until the first edge with `en_i` high. It is high after that edge and remains high until the next reset.
- R9: The register never holds the all-zero value.
- R10: With `SWAP_PAIRS` = 1, output bits 2k and 2k+1 trade places. An unpaired top bit (odd `OUT_W`) stays in place. With `SWAP_PAIRS` = 0, `rnd_o[i]` = reg[i].
- R11: With a maximal tap mask, the register returns to its start value after exactly `2^REG_LEN - 1` single steps and passes through every non-zero value on the way. Example: `REG_LEN` = 5, `TAPS` = 5'b10100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance the register by `OUT_W` steps this cycle |
| load_i | input | 1 | Replace the register with `seed_i` (zero is replaced by `SEED_INIT`) |
| seed_i | input | REG_LEN | Seed value for a load |
| rnd_o | output | OUT_W | Random word (optionally pair-swapped) |
| valid_o | output | 1 | High once the register has advanced at least once since reset |

## Verification
A seed load and an N-step advance can be requested in the same cycle. The bench provokes this by raising `load_i` and `en_i` together, once with a non-zero seed and once with an all-zero seed. It judges the result against an independent bit-serial model, which first applies the seed substitution and then takes `OUT_W` single steps. The output must equal the advanced seed, not the raw seed and not an advance of the old state.

// File: rtl/lfsr_multistep.sv
module lfsr_multistep #(
  parameter int REG_LEN = 16,
  parameter int OUT_W = 8,
  parameter logic [REG_LEN-1:0] TAPS = 'hB400,
  parameter logic [REG_LEN-1:0] SEED_INIT = 'hACE1,
  parameter bit SWAP_PAIRS = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               en_i,
  input  logic               load_i,
  input  logic [REG_LEN-1:0] seed_i,
  output logic [OUT_W-1:0]   rnd_o,
  output logic               valid_o
);

  logic [REG_LEN-1:0] state_q, base, stepped;
  logic valid_q;

  assign base = load_i ? ((seed_i == '0) ? SEED_INIT : seed_i) : state_q;

  always_comb begin
    stepped = base;
    for (int k = 0; k < OUT_W; k++)
      stepped = {stepped[REG_LEN-2:0], ^(stepped & TAPS)};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= SEED_INIT;
      valid_q <= 1'b0;
    end else begin
      state_q <= en_i ? stepped : base;
      valid_q <= valid_q | en_i;
    end
  end

  assign valid_o = valid_q;

  for (genvar i = 0; i < OUT_W; i++) begin : g_map
    localparam int SRC = (SWAP_PAIRS && ((i ^ 1) < OUT_W)) ? (i ^ 1) : i;
    assign rnd_o[i] = state_q[SRC];
  end

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i && !load_i |=> $stable(state_q));
  assert_seed_load_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i && !en_i && seed_i != '0 |=> state_q == $past(seed_i));
  assert_zero_seed_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i && !en_i && seed_i == '0 |=> state_q == SEED_INIT);
  assert_valid_sticky_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_q |=> valid_q);
  assert_valid_idle_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_q && !en_i |=> !valid_q);
  assert_nonzero_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    state_q != '0);

endmodule

// File: tb/lfsr_multistep_test.sv
module lfsr_multistep_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] TAPS = 16'hB400;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam logic [4:0] STAPS = 5'b10100;
  localparam logic [4:0] SSEED = 5'b00001;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, load = 1'b0;
  logic [15:0] seed = '0;
  logic [7:0] rnd, rnd_d;
  logic [4:0] rnd_s;
  logic valid, valid_d, valid_s;
  int checks = 0, fails = 0;
  logic [15:0] m;
  logic [4:0] ms;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_multistep uut (.clk_i(clk), .rst_i(rst), .en_i(en), .load_i(load),
    .seed_i(seed), .rnd_o(rnd), .valid_o(valid));
  lfsr_multistep #(.SWAP_PAIRS(1'b1)) uut_dither (.clk_i(clk), .rst_i(rst), .en_i(en),
    .load_i(load), .seed_i(seed), .rnd_o(rnd_d), .valid_o(valid_d));
  lfsr_multistep #(.REG_LEN(5), .OUT_W(5), .TAPS(STAPS), .SEED_INIT(SSEED)) uut_small (
    .clk_i(clk), .rst_i(rst), .en_i(en), .load_i(load), .seed_i(seed[4:0]),
    .rnd_o(rnd_s), .valid_o(valid_s));

  function automatic logic [15:0] adv(input logic [15:0] s, input int len,
                                      input logic [15:0] taps, input int n);
    logic [15:0] mask = 16'((32'd1 << len) - 1);
    for (int k = 0; k < n; k++) s = ((s << 1) | 16'(^(s & taps))) & mask;
    return s;
  endfunction

  function automatic logic [7:0] swp(input logic [7:0] w);
    logic [7:0] r;
    for (int i = 0; i < 8; i += 2) begin r[i] = w[i+1]; r[i+1] = w[i]; end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic e, input logic l, input logic [15:0] s);
    logic [15:0] b;
    logic [4:0] bs;
    en = e; load = l; seed = s;
    b = l ? ((s == 0) ? SEED : s) : m;
    bs = l ? ((s[4:0] == 0) ? SSEED : s[4:0]) : ms;
    m = e ? adv(b, 16, TAPS, 8) : b;
    ms = e ? adv({11'd0, bs}, 5, {11'd0, STAPS}, 5)[4:0] : bs;
    @(posedge clk); #1;
    en = 0; load = 0;
  endtask

  task automatic t_reset;
    rst = 1; m = SEED; ms = SSEED;
    repeat (2) @(posedge clk); #1;
    rst = 0;
    check("R1 word", {24'd0, rnd}, {24'd0, SEED[7:0]});
    check("R1 valid", {31'd0, valid}, 0);
    cycle(0, 0, 0);
    check("R8 idle valid", {31'd0, valid}, 0);
    cycle(1, 0, 0);
    check("R8 first enable", {31'd0, valid}, 1);
    check("R2 first advance", {24'd0, rnd}, {24'd0, m[7:0]});
  endtask

  task automatic t_run;
    logic [7:0] prev;
    for (int k = 0; k < 40; k++) begin
      prev = rnd;
      cycle(1, 0, 0);
      check("R3 word", {24'd0, rnd}, {24'd0, m[7:0]});
      check("R10 swap", {24'd0, rnd_d}, {24'd0, swp(m[7:0])});
      check("R9 nonzero", {31'd0, rnd_s != 0}, 1);
      check("R8 sticky", {31'd0, valid}, 1);
    end
  endtask

  task automatic t_hold;
    logic [7:0] w = rnd;
    for (int k = 0; k < 3; k++) begin
      cycle(0, 0, 16'h1234);
      check("R4 hold", {24'd0, rnd}, {24'd0, w});
    end
  endtask

  task automatic t_load;
    cycle(0, 1, 16'h5A3C);
    check("R5 seed", {24'd0, rnd}, 32'h3C);
    cycle(1, 0, 0);
    check("R5 after seed", {24'd0, rnd}, {24'd0, m[7:0]});
    cycle(0, 1, 16'h0000);
    check("R6 zero seed", {24'd0, rnd}, {24'd0, SEED[7:0]});
    check("R6 zero seed small", {27'd0, rnd_s}, {27'd0, SSEED});
  endtask

  task automatic t_load_en;
    cycle(1, 1, 16'h8001);
    check("R7 load+enable", {24'd0, rnd}, {24'd0, adv(16'h8001, 16, TAPS, 8)[7:0]});
    cycle(1, 1, 16'h0000);
    check("R7 zero load+enable", {24'd0, rnd}, {24'd0, adv(SEED, 16, TAPS, 8)[7:0]});
    check("R7 model", {24'd0, rnd}, {24'd0, m[7:0]});
  endtask

  task automatic t_period;
    logic [31:0] seen = '0;
    cycle(0, 1, 16'h0001);
    check("R11 start", {27'd0, rnd_s}, 1);
    for (int k = 1; k <= 31; k++) begin
      cycle(1, 0, 0);
      if (k < 31) check("R11 no early repeat", {31'd0, rnd_s == 5'd1}, 0);
      check("R9 small nonzero", {31'd0, rnd_s != 0}, 1);
      seen[rnd_s] = 1'b1;
    end
    check("R11 period", {27'd0, rnd_s}, 1);
    check("R11 all states", seen, 32'hFFFF_FFFE);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset;
    t_run;
    t_hold;
    t_load;
    t_load_en;
    t_period;
    t_reset;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule